// File: doc/BRIEF.md
# Hardwired Sequencer and Decoder for an 8-bit Accumulator-less CPU

This block is the control unit of a small 8-bit processor. It holds the instruction pointer, the memory address register, the instruction register and an operand register. It steps through a fixed state sequence to fetch each instruction from a synchronous RAM, decode it and execute it. The ALU, the three-entry scratch register file, the flag register and the RAM sit outside the block. The block reaches them through plain control and status pins: register selects, a write enable with a write-source select, an ALU operation code, a flag write enable, memory strobes and an address.

Instructions are one byte wide. The opcode sits in bits 7:4, the destination field in bits 3:2 and the source field in bits 1:0. Several opcodes carry more than one meaning. The decoder picks the meaning by testing whether each register field is zero. An instruction that needs an address or a constant takes a second byte, which is fetched with the same address, read and increment sequence as the opcode byte. Execution continues until HALT. HALT parks the block in a state that performs no further writes until reset.

The block has no streaming data path. Every pin is a level-sensitive control or status signal, and none uses back-pressure. Register code 00 means "no register". The external file ignores writes to it and reads it as zero.

Top module: `cpu_ctrl`

## Requirements
- R1: While reset is low and right after it, `ip` is 0, `halted` is 0, and `mem_re`, `mem_we`, `rf_we` and `flag_we` are all 0. The first fetch reads address 0.
- R2: Each instruction starts with four states. State 1 loads MAR from IP and has no strobes. State 2 raises `mem_re` for one cycle with `mem_addr` equal to IP. State 3 captures the byte and increments IP. State 4 is decode. A two-byte instruction then runs three more states that read the byte at the incremented IP and increment IP again.
- R3: Opcode 0000 decodes three ways. With both fields 00 it is a no-op. With only the source field 00 it is a two-byte direct load: a read at the operand address, then `rf_we` with source MEM. Otherwise it is an indirect load from the address held in the source register.
- R4: Opcode 0001 is a store. With the destination field 00 it is a two-byte direct store to the operand address. Otherwise it is an indirect store to the address in the destination register. Either way it raises `mem_we` for one cycle, and the source register supplies the data.
- R5: Opcode 0010 writes the destination register. With the source field 00 it is a two-byte constant load (`rf_wsrc`=2). Otherwise it copies the source register (`rf_wsrc`=3). `rf_wsrc` encodings: 0 ALU, 1 MEM, 2 IMM, 3 REGB.
- R6: With both fields 00, the following opcodes are two-byte jumps. 0100 jumps always, 0101 when V is set, 0110 when N is set, 1000 when Z is set and 1100 when C is set. A taken jump loads IP with the operand. A jump that is not taken leaves IP just past the operand.
- R7: The ALU operations and their `alu_op` codes are as follows. 0101 is add with carry (0). 0110 is subtract with borrow (1). 1000 is AND (2). 1001 is OR (3). 1010 is XOR (4). 1100 is rotate left (5). 1101 is rotate right (6). Each raises `rf_we` with source ALU and `flag_we` in one execute cycle. Opcode 0100 with nonzero fields is a compare: it uses `alu_op` 1 and raises `flag_we` without `rf_we`.
- R8: Opcode 1110 sets the carry (`alu_op` 7). Opcode 1101 with both fields 00 clears it (`alu_op` 8). Each is a one-byte `flag_we` with no register write.
- R9: After opcode 1111 executes, `halted` stays 1 and `ip` stays fixed. From then until reset, `mem_re`, `mem_we`, `rf_we` and `flag_we` stay 0.
- R10: Opcodes 0011, 0111 and 1011 are one-byte instructions that raise no write strobe.
- R11: `mem_re` and `mem_we` are never high in the same cycle. An asynchronous reset returns the block to R1 from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | RAM address, driven by the memory address register |
| mem_re | output | 1 | RAM read strobe; data is valid in the following cycle |
| mem_we | output | 1 | RAM write strobe; the source register supplies the data |
| mem_rdata | input | 8 | RAM read data |
| rf_a_sel | output | 2 | Destination register select (instruction bits 3:2) |
| rf_b_sel | output | 2 | Source register select (instruction bits 1:0) |
| rf_a_val | input | 8 | Value of the destination register, used as an indirect store address |
| rf_b_val | input | 8 | Value of the source register, used as an indirect load address |
| rf_we | output | 1 | Register file write enable for the destination register |
| rf_wsrc | output | 2 | Write source: 0 ALU, 1 MEM, 2 IMM, 3 REGB |
| imm | output | 8 | Operand byte of the current two-byte instruction |
| alu_op | output | 4 | ALU operation code |
| flag_we | output | 1 | Flag register update enable |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| ip | output | 8 | Instruction pointer |
| halted | output | 1 | High once HALT has executed |

## Verification
The bench builds the block with its default 8-bit address and data widths. With those widths the whole 256-byte address space and every opcode and field combination can be reached with a single program image. The program visits every decode leaf, including the undefined opcodes. It takes conditional jumps both ways and runs loads and stores in direct and indirect form at addresses far from the code. The bench predicts every cycle's strobes, addresses and selects from an instruction-level model, and it compares the final register and memory contents.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;
  localparam int OPC_W = 4;
  localparam int REG_W = 2;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FREAD, ST_FCAP, ST_DECODE,
    ST_OADDR, ST_OREAD, ST_OCAP, ST_EXEC,
    ST_MREAD, ST_MCAP, ST_MWRITE, ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    AOP_ADC  = 4'd0,
    AOP_SBC  = 4'd1,
    AOP_AND  = 4'd2,
    AOP_OR   = 4'd3,
    AOP_XOR  = 4'd4,
    AOP_ROL  = 4'd5,
    AOP_ROR  = 4'd6,
    AOP_SETC = 4'd7,
    AOP_CLRC = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    WS_ALU  = 2'd0,
    WS_MEM  = 2'd1,
    WS_IMM  = 2'd2,
    WS_REGB = 2'd3
  } wsrc_e;

  typedef enum logic [3:0] {
    K_NOP, K_LD_DIR, K_LD_IND, K_ST_DIR, K_ST_IND, K_LD_IMM,
    K_MOVE, K_ARITH, K_COMPARE, K_CARRY, K_BRANCH, K_STOP
  } kind_e;

  typedef enum logic [2:0] {
    CND_ALWAYS, CND_C, CND_V, CND_N, CND_Z
  } cond_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e aop;
    cond_e   cond;
    logic    two_word;
  } dec_t;
endpackage

// File: rtl/cpu_ctrl_decode.sv
module cpu_ctrl_decode
  import cpu_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ir,
  output dec_t          dec
);
  localparam int OPC_LSB = DW - OPC_W;

  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] fld_d;
  logic [REG_W-1:0] fld_s;
  logic             d_zero;
  logic             s_zero;
  logic             both_zero;

  assign opc       = ir[DW-1:OPC_LSB];
  assign fld_d     = ir[2*REG_W-1:REG_W];
  assign fld_s     = ir[REG_W-1:0];
  assign d_zero    = (fld_d == '0);
  assign s_zero    = (fld_s == '0);
  assign both_zero = d_zero && s_zero;

  // Opcodes overlap; the zero-ness of the register fields picks the meaning.
  always_comb begin
    dec.kind     = K_NOP;
    dec.aop      = AOP_ADC;
    dec.cond     = CND_ALWAYS;
    dec.two_word = 1'b0;
    unique case (opc)
      4'b0000: dec.kind = both_zero ? K_NOP : (s_zero ? K_LD_DIR : K_LD_IND);
      4'b0001: dec.kind = d_zero ? K_ST_DIR : K_ST_IND;
      4'b0010: dec.kind = s_zero ? K_LD_IMM : K_MOVE;
      4'b0100: begin
        dec.kind = both_zero ? K_BRANCH : K_COMPARE;
        dec.aop  = AOP_SBC;
        dec.cond = CND_ALWAYS;
      end
      4'b0101: begin
        dec.kind = both_zero ? K_BRANCH : K_ARITH;
        dec.aop  = AOP_ADC;
        dec.cond = CND_V;
      end
      4'b0110: begin
        dec.kind = both_zero ? K_BRANCH : K_ARITH;
        dec.aop  = AOP_SBC;
        dec.cond = CND_N;
      end
      4'b1000: begin
        dec.kind = both_zero ? K_BRANCH : K_ARITH;
        dec.aop  = AOP_AND;
        dec.cond = CND_Z;
      end
      4'b1100: begin
        dec.kind = both_zero ? K_BRANCH : K_ARITH;
        dec.aop  = AOP_ROL;
        dec.cond = CND_C;
      end
      4'b1001: begin
        dec.kind = K_ARITH;
        dec.aop  = AOP_OR;
      end
      4'b1010: begin
        dec.kind = K_ARITH;
        dec.aop  = AOP_XOR;
      end
      4'b1101: begin
        dec.kind = both_zero ? K_CARRY : K_ARITH;
        dec.aop  = both_zero ? AOP_CLRC : AOP_ROR;
      end
      4'b1110: begin
        dec.kind = K_CARRY;
        dec.aop  = AOP_SETC;
      end
      4'b1111: dec.kind = K_STOP;
      default: dec.kind = K_NOP;
    endcase
    dec.two_word = (dec.kind == K_LD_DIR) || (dec.kind == K_ST_DIR) ||
                   (dec.kind == K_LD_IMM) || (dec.kind == K_BRANCH);
  end
endmodule

// File: rtl/cpu_ctrl_cond.sv
module cpu_ctrl_cond
  import cpu_ctrl_pkg::*;
(
  input  cond_e cond,
  input  logic  flag_z,
  input  logic  flag_c,
  input  logic  flag_n,
  input  logic  flag_v,
  output logic  taken
);
  always_comb begin
    unique case (cond)
      CND_ALWAYS: taken = 1'b1;
      CND_C:      taken = flag_c;
      CND_V:      taken = flag_v;
      CND_N:      taken = flag_n;
      CND_Z:      taken = flag_z;
      default:    taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_ctrl_seq.sv
module cpu_ctrl_seq
  import cpu_ctrl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kind_e            kind,
  input  logic             two_word,
  input  logic             taken,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [DW-1:0]    rf_a_val,
  input  logic [DW-1:0]    rf_b_val,
  output logic [DW-1:0]    ir,
  output logic [DW-1:0]    opr,
  output logic [AW-1:0]    ip,
  output logic [AW-1:0]    mar,
  output logic             mem_re,
  output logic             mem_we,
  output logic             rf_we,
  output logic [1:0]       rf_wsrc,
  output logic             flag_we,
  output logic             halted
);
  localparam logic [AW-1:0] IP_STEP = AW'(1);

  state_e state;
  state_e nxt;
  wsrc_e  wsrc;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FADDR:  nxt = ST_FREAD;
      ST_FREAD:  nxt = ST_FCAP;
      ST_FCAP:   nxt = ST_DECODE;
      ST_DECODE: nxt = two_word ? ST_OADDR : ST_EXEC;
      ST_OADDR:  nxt = ST_OREAD;
      ST_OREAD:  nxt = ST_OCAP;
      ST_OCAP:   nxt = ST_EXEC;
      ST_EXEC: begin
        unique case (kind)
          K_LD_DIR, K_LD_IND: nxt = ST_MREAD;
          K_ST_DIR, K_ST_IND: nxt = ST_MWRITE;
          K_STOP:             nxt = ST_HALT;
          default:            nxt = ST_FADDR;
        endcase
      end
      ST_MREAD:  nxt = ST_MCAP;
      ST_MCAP:   nxt = ST_FADDR;
      ST_MWRITE: nxt = ST_FADDR;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FADDR;
      ip    <= '0;
      mar   <= '0;
      ir    <= '0;
      opr   <= '0;
    end else begin
      state <= nxt;
      unique case (state)
        ST_FADDR, ST_OADDR: mar <= ip;
        ST_FCAP: begin
          ir <= mem_rdata;
          ip <= ip + IP_STEP;
        end
        ST_OCAP: begin
          opr <= mem_rdata;
          ip  <= ip + IP_STEP;
        end
        ST_EXEC: begin
          unique case (kind)
            K_LD_DIR, K_ST_DIR: mar <= AW'(opr);
            K_LD_IND:           mar <= AW'(rf_b_val);
            K_ST_IND:           mar <= AW'(rf_a_val);
            K_BRANCH:           if (taken) ip <= AW'(opr);
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    wsrc = WS_ALU;
    if (state == ST_MCAP)
      wsrc = WS_MEM;
    else if (kind == K_LD_IMM)
      wsrc = WS_IMM;
    else if (kind == K_MOVE)
      wsrc = WS_REGB;
  end

  assign rf_wsrc = wsrc;
  assign mem_re  = (state == ST_FREAD) || (state == ST_OREAD) || (state == ST_MREAD);
  assign mem_we  = (state == ST_MWRITE);
  assign rf_we   = (state == ST_MCAP) ||
                   ((state == ST_EXEC) &&
                    ((kind == K_LD_IMM) || (kind == K_MOVE) || (kind == K_ARITH)));
  assign flag_we = (state == ST_EXEC) &&
                   ((kind == K_ARITH) || (kind == K_COMPARE) || (kind == K_CARRY));
  assign halted  = (state == ST_HALT);

  // R2: every byte capture advances the pointer by one
  p_ip_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCAP || state == ST_OCAP) |=> ip == $past(ip) + IP_STEP);

  // R2: the instruction register takes the byte returned by the read
  p_ir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCAP) |=> ir == $past(mem_rdata));

  // R2: a read strobe is always followed by a capture state
  p_read_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (state == ST_FCAP || state == ST_OCAP || state == ST_MCAP));

  // R6: a taken jump loads the operand into the pointer
  p_jump_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && kind == K_BRANCH && taken) |=> ip == AW'($past(opr)));

  // R6: an untaken jump leaves the pointer past the operand
  p_jump_untaken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && kind == K_BRANCH && !taken) |=> $stable(ip));

  // R7: compare updates flags and never writes a register
  p_cmp_flags_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && kind == K_COMPARE) |-> (flag_we && !rf_we));

  // R9: the halt state is terminal and silent
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(ip) && !mem_we && !mem_re && !rf_we && !flag_we));
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_ctrl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  input  logic [DW-1:0]    mem_rdata,
  output logic [REG_W-1:0] rf_a_sel,
  output logic [REG_W-1:0] rf_b_sel,
  input  logic [DW-1:0]    rf_a_val,
  input  logic [DW-1:0]    rf_b_val,
  output logic             rf_we,
  output logic [1:0]       rf_wsrc,
  output logic [DW-1:0]    imm,
  output logic [3:0]       alu_op,
  output logic             flag_we,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic             flag_n,
  input  logic             flag_v,
  output logic [AW-1:0]    ip,
  output logic             halted
);
  dec_t          dec;
  logic          taken;
  logic [DW-1:0] ir;

  cpu_ctrl_decode #(.DW(DW)) u_decode (
    .ir  (ir),
    .dec (dec)
  );

  cpu_ctrl_cond u_cond (
    .cond   (dec.cond),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .taken  (taken)
  );

  cpu_ctrl_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (dec.kind),
    .two_word  (dec.two_word),
    .taken     (taken),
    .mem_rdata (mem_rdata),
    .rf_a_val  (rf_a_val),
    .rf_b_val  (rf_b_val),
    .ir        (ir),
    .opr       (imm),
    .ip        (ip),
    .mar       (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .rf_we     (rf_we),
    .rf_wsrc   (rf_wsrc),
    .flag_we   (flag_we),
    .halted    (halted)
  );

  assign rf_a_sel = ir[2*REG_W-1:REG_W];
  assign rf_b_sel = ir[REG_W-1:0];
  assign alu_op   = dec.aop;

  // R11: the two memory strobes are mutually exclusive
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R9: no memory write or register write is issued from the halted state
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_we || rf_we));
endmodule

// File: tb/cpu_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_ctrl_bench;
  localparam int WD_CYCLES = 5000;
  localparam int K_NOP = 0, K_LDD = 1, K_LDX = 2, K_STD = 3, K_STX = 4, K_LDI = 5,
                 K_MOV = 6, K_ALU = 7, K_CMP = 8, K_CAR = 9, K_JMP = 10, K_HLT = 11, K_UND = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_rdata, rf_a_val, rf_b_val, imm, ip;
  logic [1:0] rf_a_sel, rf_b_sel, rf_wsrc;
  logic [3:0] alu_op;
  logic       mem_re, mem_we, rf_we, flag_we, halted;
  logic       flag_z, flag_c, flag_n, flag_v;

  always #4 clk = ~clk;

  cpu_ctrl u_cpu_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .rf_a_sel(rf_a_sel), .rf_b_sel(rf_b_sel), .rf_a_val(rf_a_val),
    .rf_b_val(rf_b_val), .rf_we(rf_we), .rf_wsrc(rf_wsrc), .imm(imm), .alu_op(alu_op),
    .flag_we(flag_we), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
    .ip(ip), .halted(halted)
  );

  // ALU: returns {z,c,n,v,result}
  function automatic logic [11:0] alu_f(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [3:0] fl);
    logic [8:0] w;
    logic [7:0] r;
    logic z, c, n, v;
    {z, c, n, v} = fl;
    r = a;
    case (op)
      4'd0: begin w = {1'b0, a} + {1'b0, b} + {8'd0, fl[2]}; r = w[7:0]; c = w[8];
                  v = (a[7] == b[7]) && (r[7] != a[7]); n = r[7]; z = (r == 8'd0); end
      4'd1: begin w = {1'b0, a} - {1'b0, b} - {8'd0, fl[2]}; r = w[7:0]; c = w[8];
                  v = (a[7] != b[7]) && (r[7] != a[7]); n = r[7]; z = (r == 8'd0); end
      4'd2: begin r = a & b; z = (r == 8'd0); end
      4'd3: begin r = a | b; z = (r == 8'd0); end
      4'd4: begin r = a ^ b; z = (r == 8'd0); end
      4'd5: begin r = {a[6:0], a[7]}; c = a[7]; z = (r == 8'd0); end
      4'd6: begin r = {a[0], a[7:1]}; c = a[0]; z = (r == 8'd0); end
      4'd7: c = 1'b1;
      4'd8: c = 1'b0;
      default: ;
    endcase
    return {z, c, n, v, r};
  endfunction

  // External parts driven by the block
  logic [7:0]  ram [256];
  logic [7:0]  b_rf [4];
  logic [3:0]  b_fl;
  logic [7:0]  rdata_q;
  logic [11:0] alu_res;
  logic [7:0]  wval;

  assign rf_a_val  = b_rf[rf_a_sel];
  assign rf_b_val  = b_rf[rf_b_sel];
  assign mem_rdata = rdata_q;
  assign {flag_z, flag_c, flag_n, flag_v} = b_fl;
  assign alu_res   = alu_f(alu_op, rf_a_val, rf_b_val, b_fl);

  always_comb begin
    case (rf_wsrc)
      2'd0: wval = alu_res[7:0];
      2'd1: wval = rdata_q;
      2'd2: wval = imm;
      default: wval = rf_b_val;
    endcase
  end

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= rf_b_val;
    if (mem_re) rdata_q <= ram[mem_addr];
    if (rf_we && rf_a_sel != 2'd0) b_rf[rf_a_sel] <= wval;
    if (flag_we) b_fl <= alu_res[11:8];
  end

  // Reference model
  typedef struct {
    bit [4:0] strobes;   // {re, we, rfwe, fwe, halted}
    bit [7:0] addr;
    bit [1:0] ws;
    bit [3:0] aop;
    int       tag;
  } exp_t;

  exp_t     q[$];
  bit [7:0] m_mem [256];
  bit [7:0] m_reg [4];
  bit [3:0] m_fl;
  bit [7:0] m_ip;
  bit       m_halt;
  int       n_chk;
  int       n_fail;

  function automatic exp_t mk(bit [4:0] s, bit [7:0] a, bit [1:0] w, bit [3:0] o, int t);
    exp_t e;
    e.strobes = s; e.addr = a; e.ws = w; e.aop = o; e.tag = t;
    return e;
  endfunction

  task automatic chk(bit ok, int tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic put(input int a, input bit [7:0] v);
    ram[a]   = v;
    m_mem[a] = v;
  endtask

  task automatic model_step();
    bit [7:0]  ins, opnd, addr;
    bit [3:0]  op, aop;
    bit [1:0]  rd, rs;
    bit        both, two, tk;
    bit [11:0] r;
    int        kind, cnd, tag;
    ins  = m_mem[m_ip];
    op   = ins[7:4]; rd = ins[3:2]; rs = ins[1:0];
    both = (rd == 0) && (rs == 0);
    kind = K_UND; aop = 0; cnd = 0;
    case (op)
      4'h0: kind = both ? K_NOP : ((rs == 0) ? K_LDD : K_LDX);
      4'h1: kind = (rd == 0) ? K_STD : K_STX;
      4'h2: kind = (rs == 0) ? K_LDI : K_MOV;
      4'h4: begin kind = both ? K_JMP : K_CMP; aop = 1; cnd = 0; end
      4'h5: begin kind = both ? K_JMP : K_ALU; aop = 0; cnd = 2; end
      4'h6: begin kind = both ? K_JMP : K_ALU; aop = 1; cnd = 3; end
      4'h8: begin kind = both ? K_JMP : K_ALU; aop = 2; cnd = 4; end
      4'hC: begin kind = both ? K_JMP : K_ALU; aop = 5; cnd = 1; end
      4'h9: begin kind = K_ALU; aop = 3; end
      4'hA: begin kind = K_ALU; aop = 4; end
      4'hD: begin kind = both ? K_CAR : K_ALU; aop = both ? 4'd8 : 4'd6; end
      4'hE: begin kind = K_CAR; aop = 7; end
      4'hF: kind = K_HLT;
      default: kind = K_UND;
    endcase
    case (kind)   // requirement owning each execute record
      K_NOP, K_LDD, K_LDX: tag = 3;
      K_STD, K_STX:        tag = 4;
      K_LDI, K_MOV:        tag = 5;
      K_JMP:               tag = 6;
      K_ALU, K_CMP:        tag = 7;
      K_CAR:               tag = 8;
      K_HLT:               tag = 9;
      default:             tag = 10;
    endcase
    two = (kind == K_LDD) || (kind == K_STD) || (kind == K_LDI) || (kind == K_JMP);
    // R2: opcode fetch states
    q.push_back(mk(5'b00000, 0, 0, 0, 2));
    q.push_back(mk(5'b10000, m_ip, 0, 0, 2));
    q.push_back(mk(5'b00000, 0, 0, 0, 2));
    q.push_back(mk(5'b00000, 0, 0, 0, 2));
    opnd = 0;
    if (two) begin
      q.push_back(mk(5'b00000, 0, 0, 0, 2));
      q.push_back(mk(5'b10000, m_ip + 8'd1, 0, 0, 2));
      q.push_back(mk(5'b00000, 0, 0, 0, 2));
      opnd = m_mem[m_ip + 8'd1];
      m_ip = m_ip + 8'd2;
    end else begin
      m_ip = m_ip + 8'd1;
    end
    case (kind)
      K_LDI: begin
        q.push_back(mk(5'b00100, 0, 2, 0, tag));
        if (rd != 0) m_reg[rd] = opnd;
      end
      K_MOV: begin
        q.push_back(mk(5'b00100, 0, 3, 0, tag));
        if (rd != 0) m_reg[rd] = m_reg[rs];
      end
      K_ALU: begin
        q.push_back(mk(5'b00110, 0, 0, aop, tag));
        r = alu_f(aop, m_reg[rd], m_reg[rs], m_fl);
        if (rd != 0) m_reg[rd] = r[7:0];
        m_fl = r[11:8];
      end
      K_CMP, K_CAR: begin
        q.push_back(mk(5'b00010, 0, 0, aop, tag));
        r = alu_f(aop, m_reg[rd], m_reg[rs], m_fl);
        m_fl = r[11:8];
      end
      K_JMP: begin
        q.push_back(mk(5'b00000, 0, 0, 0, tag));
        case (cnd)
          1: tk = m_fl[2];
          2: tk = m_fl[0];
          3: tk = m_fl[1];
          4: tk = m_fl[3];
          default: tk = 1'b1;
        endcase
        if (tk) m_ip = opnd;
      end
      K_LDD, K_LDX: begin
        addr = (kind == K_LDD) ? opnd : m_reg[rs];
        q.push_back(mk(5'b00000, 0, 0, 0, tag));
        q.push_back(mk(5'b10000, addr, 0, 0, tag));
        q.push_back(mk(5'b00100, 0, 1, 0, tag));
        if (rd != 0) m_reg[rd] = m_mem[addr];
      end
      K_STD, K_STX: begin
        addr = (kind == K_STD) ? opnd : m_reg[rd];
        q.push_back(mk(5'b00000, 0, 0, 0, tag));
        q.push_back(mk(5'b01000, addr, 0, 0, tag));
        m_mem[addr] = m_reg[rs];
      end
      K_HLT: begin
        q.push_back(mk(5'b00000, 0, 0, 0, tag));
        m_halt = 1'b1;
      end
      default: q.push_back(mk(5'b00000, 0, 0, 0, tag));
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    exp_t e;
    int   cyc, post;
    bit   stop;
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; m_mem[i] = 8'h00; end
    for (int i = 0; i < 4; i++) begin b_rf[i] = 8'h00; m_reg[i] = 8'h00; end
    b_fl = 4'h0; m_fl = 4'h0; m_ip = 8'h00; m_halt = 1'b0; rdata_q = 8'h00;
    n_chk = 0; n_fail = 0;
    // program: R5 const loads, R8 set carry, R7 add, R6 taken carry jump
    put(0, 8'h24); put(1, 8'h0F); put(2, 8'h28); put(3, 8'hF1);
    put(4, 8'hE0); put(5, 8'h56); put(6, 8'hC0); put(7, 8'h0A);
    put(8, 8'hF0); put(9, 8'h00);
    // R4 direct store, R3 direct load, R5 transfer, R8 clear carry, R7 subtract
    put(10, 8'h11); put(11, 8'h80); put(12, 8'h0C); put(13, 8'h80);
    put(14, 8'h2B); put(15, 8'hD0); put(16, 8'h69);
    // R6 untaken negative jump, taken zero jump
    put(17, 8'h60); put(18, 8'h40); put(19, 8'h80); put(20, 8'h16); put(21, 8'hF0);
    // R4 indirect store, R3 indirect load, R7 logic, rotates, compare
    put(22, 8'h2C); put(23, 8'h90); put(24, 8'h1D); put(25, 8'h0B);
    put(26, 8'h8B); put(27, 8'h97); put(28, 8'hA6); put(29, 8'hC4);
    put(30, 8'hD8); put(31, 8'h46);
    // R10 undefined opcodes, R6 overflow jump, R3 no-op, R6 unconditional jump, R9 halt
    put(32, 8'h3F); put(33, 8'h75); put(34, 8'hBA); put(35, 8'h50); put(36, 8'h25);
    put(37, 8'h00); put(38, 8'h40); put(39, 8'h29); put(40, 8'hF0); put(41, 8'hF0);

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ip == 8'h00, 1, "ip in reset", ip, 0);
    chk(halted == 1'b0, 1, "halted in reset", halted, 0);
    chk({mem_re, mem_we, rf_we, flag_we} == 4'h0, 1, "strobes in reset",
        {mem_re, mem_we, rf_we, flag_we}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    cyc = 0; post = 0; stop = 1'b0;
    while (!stop) begin
      if (q.size() == 0) begin
        if (m_halt) q.push_back(mk(5'b00001, 0, 0, 0, 9));
        else model_step();
      end
      e = q.pop_front();
      chk({mem_re, mem_we, rf_we, flag_we, halted} == e.strobes, e.tag, "strobes",
          {mem_re, mem_we, rf_we, flag_we, halted}, e.strobes);
      if (e.strobes[4] || e.strobes[3])
        chk(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
      if (e.strobes[2])
        chk(rf_wsrc == e.ws, e.tag, "rf_wsrc", rf_wsrc, e.ws);
      if (e.strobes[1] || (e.strobes[2] && e.ws == 2'd0))
        chk(alu_op == e.aop, e.tag, "alu_op", alu_op, e.aop);
      if (e.strobes[0]) post++;
      if (post >= 16) stop = 1'b1;
      cyc++;
      if (cyc >= WD_CYCLES) begin
        n_fail++;
        $display("FAIL R9 run did not halt, actual=running expected=halted");
        stop = 1'b1;
      end
      @(negedge clk);
      #1;
    end
    // R9 end state against the model
    chk(ip == m_ip, 9, "ip after halt", ip, m_ip);
    for (int i = 1; i < 4; i++)
      chk(b_rf[i] == m_reg[i], 7, "register contents", b_rf[i], m_reg[i]);
    chk(ram[8'h80] == m_mem[8'h80], 4, "direct store cell", ram[8'h80], m_mem[8'h80]);
    chk(ram[8'h90] == m_mem[8'h90], 4, "indirect store cell", ram[8'h90], m_mem[8'h90]);
    chk(b_fl == m_fl, 8, "flags", b_fl, m_fl);
    // R11 asynchronous reset from the halted state
    rst_n = 1'b0;
    #1;
    chk(ip == 8'h00, 11, "ip after async reset", ip, 0);
    chk(halted == 1'b0, 11, "halted after async reset", halted, 0);
    @(negedge clk);
    summary();
  end
endmodule